// File: doc/BRIEF.md
# Byte Command Responder

This block interprets single-byte commands that arrive from a serial byte link, one byte per cycle with a one-cycle valid strobe, for a small wheeled controller. A command byte may be followed by parameter bytes. Replies are written into a transmit queue, which presents them one at a time with a valid/acknowledge handshake. The block also reads four sensor values (two distance, two wheel-position). It issues a one-cycle clear pulse to the wheel-position counters. It holds the motor drive settings: two duty bytes, two 8-bit control bytes and two polarity bits.

A host can ask for a snapshot of the distance sensors, read and zero the wheel counters, or rewrite the motor settings in two formats: a packed form with a flags byte, and a raw form with four bytes. It can also arm an automatic distance report. The report is sent once, without a request, when either distance reaches its armed threshold. All multi-byte values travel least significant byte first. The value width is a parameter that must be a multiple of eight (default 16 bits). The queue depth is a power-of-two parameter (default 16).

Top module: `byte_cmd_responder`

## Requirements
- R1: A received byte 0x50 while no command is collecting parameters queues exactly one reply byte, 0x50.
- R2: Any command byte other than 0x50, 0x43, 0x44, 0x63, 0x57 or 0x77 queues the two bytes 0x45 then 0x43.
- R3: `tx_valid` is high exactly while the queue holds a byte. `tx_byte` stays unchanged until a cycle with `tx_ack` high, after which the next byte is shown. `tx_ack` while the queue is empty has no effect.
- R4: Replies to commands received in consecutive cycles leave the queue whole and in arrival order.
- R5: 0x43 queues 0x43, then the front distance, then the back distance, each least significant byte first, with the values present in the cycle the command byte is taken.
- R6: 0x44 raises `enc_clear` for the single cycle after the command byte is taken. It queues 0x44, then the left and right wheel values (low byte first) as they were in the cycle the command byte was taken.
- R7: 0x63 takes four more bytes: the front threshold (low, high), then the back threshold (low, high). It queues no reply of its own and arms the automatic report.
- R8: While armed, in the first cycle where front >= front threshold or back >= back threshold and no command reply is being queued, the block queues 0x43 plus both distances (same format as R5) and disarms. A reply queued in that cycle goes ahead of the report, which follows in a later cycle if the condition still holds.
- R9: 0x57 takes three bytes: `duty_a`, `duty_b`, then a flags byte. Flag bit0 sets `ctl_a` to 0xFF (else 0x00), bit1 drives `pol_a`, bit2 sets `ctl_b` to 0xFF (else 0x00), and bit3 drives `pol_b`.
- R10: 0x77 takes four bytes and loads them, in that order, into `duty_a`, `ctl_a`, `duty_b` and `ctl_b`, leaving the polarity bits unchanged.
- R11: The queue holds 16 bytes at default depth. A reply byte that finds no free entry (counting only entries free before this cycle's removal) is discarded, and queued bytes are kept.
- R12: Synchronous active-high `rst` empties the queue, returns the parser to command mode, disarms the report, zeroes all motor outputs and holds `enc_clear` low.
- R13: A byte taken as a parameter is never decoded as a command and queues no reply, even if it equals a command code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_byte | input | 8 | Received byte |
| rx_valid | input | 1 | One-cycle strobe qualifying `rx_byte` |
| dist_front | input | VAL_W | Front distance value |
| dist_back | input | VAL_W | Back distance value |
| enc_left | input | VAL_W | Left wheel position |
| enc_right | input | VAL_W | Right wheel position |
| tx_byte | output | 8 | Byte at the head of the reply queue |
| tx_valid | output | 1 | High while the queue is not empty |
| tx_ack | input | 1 | Removes the head byte when `tx_valid` is high |
| enc_clear | output | 1 | One-cycle wheel counter clear |
| duty_a | output | 8 | Motor A duty |
| ctl_a | output | 8 | Motor A control byte |
| pol_a | output | 1 | Motor A polarity |
| duty_b | output | 8 | Motor B duty |
| ctl_b | output | 8 | Motor B control byte |
| pol_b | output | 1 | Motor B polarity |

## Verification
The automatic distance report and a command reply can both want the queue in the same cycle. The bench provokes this by arming with zero thresholds, so the condition holds at once, and then sending a ping in the very next cycle. It is judged by the ping byte coming out ahead of the report, and by the report still appearing exactly once. A second overlap is a queue removal in the same cycle as a write into a full queue. It is driven by random acknowledges against bursts of five-byte replies, and a per-clock reference model of the queue checks which bytes survive.

// File: rtl/cmdr_pkg.sv
package cmdr_pkg;
   localparam int BYTE_W = 8;

   localparam logic [7:0] OP_PING   = 8'h50;
   localparam logic [7:0] OP_SNAP   = 8'h43;
   localparam logic [7:0] OP_ENC    = 8'h44;
   localparam logic [7:0] OP_ARM    = 8'h63;
   localparam logic [7:0] OP_PACKED = 8'h57;
   localparam logic [7:0] OP_RAW    = 8'h77;
   localparam logic [7:0] ERR_FIRST = 8'h45;
   localparam logic [7:0] ERR_NEXT  = 8'h43;

   typedef enum logic [1:0] {
      PS_IDLE,
      PS_THRESH,
      PS_PACKED,
      PS_RAW
   } pstate_e;
endpackage

// File: rtl/cmdr_txq.sv
module cmdr_txq #(
   parameter int DEPTH = 16,
   parameter int LANES = 5,
   localparam int AW = $clog2(DEPTH),
   localparam int CW = $clog2(DEPTH + 1),
   localparam int NW = $clog2(LANES + 1)
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic [NW-1:0]         push_n,
   input  logic [LANES*8-1:0]    push_data,
   input  logic                  pop,
   output logic                  out_valid,
   output logic [7:0]            out_data
);
   logic [7:0]    mem [DEPTH];
   logic [AW-1:0] rd_ptr;
   logic [AW-1:0] wr_ptr;
   logic [CW-1:0] level;
   logic [CW-1:0] room;
   logic [CW-1:0] take;
   logic          do_pop;

   initial begin
      chk_depth_pow2: assert (DEPTH >= 2 && (1 << AW) == DEPTH)
         else $error("queue depth must be a power of two, at least 2");
      chk_lanes_fit: assert (LANES >= 1 && LANES <= DEPTH)
         else $error("push lanes must fit in the queue");
   end

   assign room      = CW'(DEPTH) - level;
   assign take      = (CW'(push_n) > room) ? room : CW'(push_n);
   assign do_pop    = pop && (level != '0);
   assign out_valid = (level != '0);
   assign out_data  = mem[rd_ptr];

   always_ff @(posedge clk) begin
      for (int i = 0; i < LANES; i++) begin
         if (CW'(i) < take) begin
            mem[wr_ptr + AW'(i)] <= push_data[i*8 +: 8];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         rd_ptr <= '0;
         wr_ptr <= '0;
         level  <= '0;
      end else begin
         rd_ptr <= rd_ptr + AW'(do_pop);
         wr_ptr <= wr_ptr + AW'(take);
         level  <= level + take - CW'(do_pop);
      end
   end

   assert_no_overflow_R11: assert property (@(posedge clk) disable iff (rst)
      level <= CW'(DEPTH));

   assert_full_kept_R11: assert property (@(posedge clk) disable iff (rst)
      (level == CW'(DEPTH) && !pop) |=> (level == CW'(DEPTH) && $stable(out_data)));

   assert_hold_head_R3: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !pop) |=> (out_valid && $stable(out_data)));
endmodule

// File: rtl/cmdr_trigger.sv
module cmdr_trigger #(
   parameter int VW = 16
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          arm,
   input  logic [VW-1:0] arm_front,
   input  logic [VW-1:0] arm_back,
   input  logic [VW-1:0] front,
   input  logic [VW-1:0] back,
   input  logic          busy,
   output logic          fire
);
   logic          armed;
   logic [VW-1:0] thr_front;
   logic [VW-1:0] thr_back;
   logic          reached;

   assign reached = (front >= thr_front) || (back >= thr_back);
   assign fire    = armed && reached && !busy;

   always_ff @(posedge clk) begin
      if (rst) begin
         armed     <= 1'b0;
         thr_front <= '0;
         thr_back  <= '0;
      end else if (arm) begin
         armed     <= 1'b1;
         thr_front <= arm_front;
         thr_back  <= arm_back;
      end else if (fire) begin
         armed     <= 1'b0;
      end
   end

   assert_fires_once_R8: assert property (@(posedge clk) disable iff (rst)
      (fire && !arm) |=> (!armed && !fire));

   assert_yields_R8: assert property (@(posedge clk) disable iff (rst)
      (armed && reached && busy && !arm) |=> armed);
endmodule

// File: rtl/cmdr_parser.sv
module cmdr_parser
   import cmdr_pkg::*;
#(
   parameter int VW    = 16,
   parameter int LANES = 5,
   parameter int NW    = 3
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [7:0]         rx_byte,
   input  logic               rx_valid,
   input  logic [VW-1:0]      front,
   input  logic [VW-1:0]      back,
   input  logic [VW-1:0]      left,
   input  logic [VW-1:0]      right,
   output logic [NW-1:0]      push_n,
   output logic [LANES*8-1:0] push_data,
   output logic [LANES*8-1:0] sens_reply,
   output logic               enc_clear,
   output logic               arm,
   output logic [VW-1:0]      arm_front,
   output logic [VW-1:0]      arm_back,
   output logic [7:0]         duty_a,
   output logic [7:0]         ctl_a,
   output logic               pol_a,
   output logic [7:0]         duty_b,
   output logic [7:0]         ctl_b,
   output logic               pol_b
);
   localparam int VB        = VW / BYTE_W;
   localparam int ARGS      = (2 * VB > 4) ? 2 * VB : 4;
   localparam int KW        = $clog2(ARGS);
   localparam int THR_LAST  = 2 * VB - 1;
   localparam int PACK_LAST = 2;
   localparam int RAW_LAST  = 3;

   pstate_e       state;
   logic [KW-1:0] cnt;
   logic [7:0]    argb [ARGS];
   logic [LANES*8-1:0] enc_reply;
   logic          last;

   initial begin
      chk_value_bytes: assert (VW >= 8 && VW % 8 == 0)
         else $error("value width must be a whole number of bytes");
      chk_lane_count: assert (LANES == 1 + 2 * VB)
         else $error("lane count must cover a tag and two values");
   end

   assign sens_reply[7:0] = OP_SNAP;
   assign enc_reply[7:0]  = OP_ENC;

   for (genvar j = 0; j < VB; j++) begin : g_reply_bytes
      assign sens_reply[(1 + j) * 8 +: 8]      = front[j*8 +: 8];
      assign sens_reply[(1 + VB + j) * 8 +: 8] = back[j*8 +: 8];
      assign enc_reply[(1 + j) * 8 +: 8]       = left[j*8 +: 8];
      assign enc_reply[(1 + VB + j) * 8 +: 8]  = right[j*8 +: 8];
      assign arm_front[j*8 +: 8]               = argb[j];
   end

   for (genvar j = 0; j < VB - 1; j++) begin : g_thr_back
      assign arm_back[j*8 +: 8] = argb[VB + j];
   end
   assign arm_back[VW-1 -: 8] = rx_byte;

   always_comb begin
      unique case (state)
         PS_THRESH: last = (cnt == KW'(THR_LAST));
         PS_PACKED: last = (cnt == KW'(PACK_LAST));
         PS_RAW:    last = (cnt == KW'(RAW_LAST));
         default:   last = 1'b0;
      endcase
   end

   always_comb begin
      push_n    = '0;
      push_data = '0;
      arm       = 1'b0;
      if (rx_valid) begin
         if (state == PS_IDLE) begin
            unique case (rx_byte)
               OP_PING: begin
                  push_n         = NW'(1);
                  push_data[7:0] = OP_PING;
               end
               OP_SNAP: begin
                  push_n    = NW'(LANES);
                  push_data = sens_reply;
               end
               OP_ENC: begin
                  push_n    = NW'(LANES);
                  push_data = enc_reply;
               end
               OP_ARM, OP_PACKED, OP_RAW: begin
                  push_n = '0;
               end
               default: begin
                  push_n          = NW'(2);
                  push_data[15:0] = {ERR_NEXT, ERR_FIRST};
               end
            endcase
         end else if (state == PS_THRESH) begin
            arm = last;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rx_valid && state != PS_IDLE) begin
         argb[cnt] <= rx_byte;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state     <= PS_IDLE;
         cnt       <= '0;
         enc_clear <= 1'b0;
         duty_a    <= '0;
         ctl_a     <= '0;
         pol_a     <= 1'b0;
         duty_b    <= '0;
         ctl_b     <= '0;
         pol_b     <= 1'b0;
      end else begin
         enc_clear <= rx_valid && (state == PS_IDLE) && (rx_byte == OP_ENC);
         if (rx_valid) begin
            if (state == PS_IDLE) begin
               cnt <= '0;
               unique case (rx_byte)
                  OP_ARM:    state <= PS_THRESH;
                  OP_PACKED: state <= PS_PACKED;
                  OP_RAW:    state <= PS_RAW;
                  default:   state <= PS_IDLE;
               endcase
            end else if (last) begin
               state <= PS_IDLE;
               cnt   <= '0;
               if (state == PS_PACKED) begin
                  duty_a <= argb[0];
                  duty_b <= argb[1];
                  ctl_a  <= {8{rx_byte[0]}};
                  pol_a  <= rx_byte[1];
                  ctl_b  <= {8{rx_byte[2]}};
                  pol_b  <= rx_byte[3];
               end else if (state == PS_RAW) begin
                  duty_a <= argb[0];
                  ctl_a  <= argb[1];
                  duty_b <= argb[2];
                  ctl_b  <= rx_byte;
               end
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   end

   assert_clear_with_reply_R6: assert property (@(posedge clk) disable iff (rst)
      enc_clear |-> ($past(push_n) == NW'(LANES)));

   assert_param_silent_R13: assert property (@(posedge clk) disable iff (rst)
      (rx_valid && state != PS_IDLE) |-> (push_n == '0));
endmodule

// File: rtl/byte_cmd_responder.sv
module byte_cmd_responder #(
   parameter int VAL_W   = 16,
   parameter int Q_DEPTH = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [7:0]       rx_byte,
   input  logic             rx_valid,
   input  logic [VAL_W-1:0] dist_front,
   input  logic [VAL_W-1:0] dist_back,
   input  logic [VAL_W-1:0] enc_left,
   input  logic [VAL_W-1:0] enc_right,
   output logic [7:0]       tx_byte,
   output logic             tx_valid,
   input  logic             tx_ack,
   output logic             enc_clear,
   output logic [7:0]       duty_a,
   output logic [7:0]       ctl_a,
   output logic             pol_a,
   output logic [7:0]       duty_b,
   output logic [7:0]       ctl_b,
   output logic             pol_b
);
   localparam int LANES = 1 + 2 * (VAL_W / 8);
   localparam int NW    = $clog2(LANES + 1);

   logic [NW-1:0]      p_push_n;
   logic [LANES*8-1:0] p_push_data;
   logic [LANES*8-1:0] sens_reply;
   logic               arm;
   logic [VAL_W-1:0]   arm_front;
   logic [VAL_W-1:0]   arm_back;
   logic               fire;
   logic [NW-1:0]      q_push_n;
   logic [LANES*8-1:0] q_push_data;

   cmdr_parser #(.VW(VAL_W), .LANES(LANES), .NW(NW)) u_parser (
      .clk(clk), .rst(rst), .rx_byte(rx_byte), .rx_valid(rx_valid),
      .front(dist_front), .back(dist_back), .left(enc_left), .right(enc_right),
      .push_n(p_push_n), .push_data(p_push_data), .sens_reply(sens_reply),
      .enc_clear(enc_clear), .arm(arm), .arm_front(arm_front), .arm_back(arm_back),
      .duty_a(duty_a), .ctl_a(ctl_a), .pol_a(pol_a),
      .duty_b(duty_b), .ctl_b(ctl_b), .pol_b(pol_b)
   );

   cmdr_trigger #(.VW(VAL_W)) u_trigger (
      .clk(clk), .rst(rst), .arm(arm), .arm_front(arm_front), .arm_back(arm_back),
      .front(dist_front), .back(dist_back), .busy(p_push_n != '0), .fire(fire)
   );

   assign q_push_n    = fire ? NW'(LANES) : p_push_n;
   assign q_push_data = fire ? sens_reply : p_push_data;

   cmdr_txq #(.DEPTH(Q_DEPTH), .LANES(LANES)) u_txq (
      .clk(clk), .rst(rst), .push_n(q_push_n), .push_data(q_push_data),
      .pop(tx_ack), .out_valid(tx_valid), .out_data(tx_byte)
   );

   assert_reset_quiet_R12: assert property (@(posedge clk)
      $past(rst) |-> (!tx_valid && !enc_clear && duty_a == '0 && ctl_b == '0));
endmodule

// File: tb/byte_cmd_responder_bench.sv
module byte_cmd_responder_bench;
   localparam int CLK_PERIOD = 10;
   localparam int DEPTH      = 16;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [7:0]  rx_byte = '0;
   logic        rx_valid = 1'b0;
   logic [15:0] dist_front = '0, dist_back = '0, enc_left = '0, enc_right = '0;
   logic [7:0]  tx_byte;
   logic        tx_valid;
   logic        tx_ack = 1'b0;
   logic        enc_clear;
   logic [7:0]  duty_a, ctl_a, duty_b, ctl_b;
   logic        pol_a, pol_b;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   byte_cmd_responder u_byte_cmd_responder (
      .clk(clk), .rst(rst), .rx_byte(rx_byte), .rx_valid(rx_valid),
      .dist_front(dist_front), .dist_back(dist_back),
      .enc_left(enc_left), .enc_right(enc_right),
      .tx_byte(tx_byte), .tx_valid(tx_valid), .tx_ack(tx_ack),
      .enc_clear(enc_clear),
      .duty_a(duty_a), .ctl_a(ctl_a), .pol_a(pol_a),
      .duty_b(duty_b), .ctl_b(ctl_b), .pol_b(pol_b)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // ---------------- reference model, stepped on every rising edge ----------------
   logic [7:0]  mq [$];
   logic [7:0]  rep [$];
   int          mst = 0;
   int          mcnt = 0;
   logic [7:0]  mb [4];
   logic [7:0]  m_da = 0, m_db = 0, m_ca = 0, m_cb = 0;
   logic        m_pa = 0, m_pb = 0, m_clr = 0, m_armed = 0;
   logic [15:0] m_tf = 0, m_tb = 0;
   bit          started = 0;

   always @(posedge clk) begin
      int   pre;
      int   acc;
      bit   popit, newarm, fire, clr;
      logic [15:0] nf, nb;
      if (rst) begin
         mq.delete();
         mst = 0; mcnt = 0;
         m_da = 0; m_db = 0; m_ca = 0; m_cb = 0; m_pa = 0; m_pb = 0;
         m_clr = 0; m_armed = 0; m_tf = 0; m_tb = 0;
      end else begin
         rep.delete();
         pre = mq.size();
         popit = (pre > 0) && tx_ack;
         newarm = 0; clr = 0; nf = 0; nb = 0;
         if (rx_valid) begin
            if (mst == 0) begin
               case (rx_byte)
                  8'h50: rep.push_back(8'h50);
                  8'h43: begin
                     rep.push_back(8'h43);
                     rep.push_back(dist_front[7:0]); rep.push_back(dist_front[15:8]);
                     rep.push_back(dist_back[7:0]);  rep.push_back(dist_back[15:8]);
                  end
                  8'h44: begin
                     clr = 1;
                     rep.push_back(8'h44);
                     rep.push_back(enc_left[7:0]);  rep.push_back(enc_left[15:8]);
                     rep.push_back(enc_right[7:0]); rep.push_back(enc_right[15:8]);
                  end
                  8'h63: begin mst = 1; mcnt = 0; end
                  8'h57: begin mst = 2; mcnt = 0; end
                  8'h77: begin mst = 3; mcnt = 0; end
                  default: begin rep.push_back(8'h45); rep.push_back(8'h43); end
               endcase
            end else begin
               mb[mcnt] = rx_byte;
               mcnt++;
               if (mst == 1 && mcnt == 4) begin
                  nf = {mb[1], mb[0]}; nb = {mb[3], mb[2]}; newarm = 1; mst = 0;
               end else if (mst == 2 && mcnt == 3) begin
                  m_da = mb[0]; m_db = mb[1];
                  m_ca = mb[2][0] ? 8'hFF : 8'h00; m_pa = mb[2][1];
                  m_cb = mb[2][2] ? 8'hFF : 8'h00; m_pb = mb[2][3];
                  mst = 0;
               end else if (mst == 3 && mcnt == 4) begin
                  m_da = mb[0]; m_ca = mb[1]; m_db = mb[2]; m_cb = mb[3];
                  mst = 0;
               end
            end
         end
         fire = m_armed && ((dist_front >= m_tf) || (dist_back >= m_tb)) && (rep.size() == 0);
         if (fire) begin
            rep.push_back(8'h43);
            rep.push_back(dist_front[7:0]); rep.push_back(dist_front[15:8]);
            rep.push_back(dist_back[7:0]);  rep.push_back(dist_back[15:8]);
         end
         if (newarm) begin m_armed = 1; m_tf = nf; m_tb = nb; end
         else if (fire) m_armed = 0;
         if (popit) void'(mq.pop_front());
         acc = 0;
         foreach (rep[i]) begin
            if (pre + acc < DEPTH) begin
               mq.push_back(rep[i]);
               acc++;
            end
         end
         m_clr = clr;
      end
      started = 1;
   end

   // per-cycle comparison, away from the active edge
   always @(negedge clk) begin
      if (started && !done) begin
         check("R3 tx_valid", tx_valid, mq.size() != 0);
         if (mq.size() != 0) check("R4 tx_byte order", tx_byte, mq[0]);
         check("R6 enc_clear", enc_clear, m_clr);
         check("R10 duty_a", duty_a, m_da);
         check("R10 ctl_a", ctl_a, m_ca);
         check("R10 duty_b", duty_b, m_db);
         check("R10 ctl_b", ctl_b, m_cb);
         check("R9 pol_a", pol_a, m_pa);
         check("R9 pol_b", pol_b, m_pb);
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic send(input logic [7:0] b);
      rx_byte = b;
      rx_valid = 1'b1;
      @(negedge clk);
      rx_valid = 1'b0;
   endtask

   task automatic expect_reply(input string tag, input logic [7:0] exp [$]);
      foreach (exp[i]) begin
         for (int w = 0; w < 40 && !tx_valid; w++) @(negedge clk);
         check(tag, tx_byte, exp[i]);
         tx_ack = 1'b1;
         @(negedge clk);
         tx_ack = 1'b0;
      end
      check({tag, " drained"}, tx_valid, 1'b0);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      finish_run();
   end

   initial begin
      logic [7:0] q [$];
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R12: state after reset
      check("R12 tx_valid", tx_valid, 0);
      check("R12 enc_clear", enc_clear, 0);
      check("R12 motors", {duty_a, ctl_a, duty_b, ctl_b, pol_a, pol_b}, 0);

      send(8'h50);
      expect_reply("R1 ping", '{8'h50});

      send(8'h3F);
      expect_reply("R2 unknown", '{8'h45, 8'h43});

      send(8'h50); send(8'h50); send(8'h50);
      expect_reply("R4 back-to-back", '{8'h50, 8'h50, 8'h50});

      dist_front = 16'd1152; dist_back = 16'd11614;
      send(8'h43);
      expect_reply("R5 snapshot", '{8'h43, 8'h80, 8'h04, 8'h5E, 8'h2D});

      enc_left = 16'd1152; enc_right = 16'd11614;
      send(8'h44);
      check("R6 clear high", enc_clear, 1);
      enc_left = 16'd0; enc_right = 16'd0;
      @(negedge clk);
      check("R6 clear single", enc_clear, 0);
      expect_reply("R6 wheel reply", '{8'h44, 8'h80, 8'h04, 8'h5E, 8'h2D});

      dist_front = 0; dist_back = 0;
      send(8'h63); send(8'h5E); send(8'h2D); send(8'h5E); send(8'h2D);
      repeat (3) @(negedge clk);
      check("R7 arm silent", tx_valid, 0);
      dist_front = 16'd11614;
      @(negedge clk);
      expect_reply("R8 auto report", '{8'h43, 8'h5E, 8'h2D, 8'h00, 8'h00});
      repeat (4) @(negedge clk);
      check("R8 fires once", tx_valid, 0);

      // report and ping wanting the queue in the same cycle
      send(8'h63); send(8'h00); send(8'h00); send(8'h00); send(8'h00);
      send(8'h50);
      expect_reply("R8 ping first", '{8'h50, 8'h43, 8'h5E, 8'h2D, 8'h00, 8'h00});

      send(8'h57); send(8'hCC); send(8'h77); send(8'h03);
      check("R9 duty_a", duty_a, 8'hCC);
      check("R9 duty_b", duty_b, 8'h77);
      check("R9 ctl_a", ctl_a, 8'hFF);
      check("R9 pol_a", pol_a, 1);
      check("R9 ctl_b", ctl_b, 8'h00);
      check("R9 pol_b", pol_b, 0);

      send(8'h77); send(8'h11); send(8'h22); send(8'h33); send(8'h44);
      check("R10 raw", {duty_a, ctl_a, duty_b, ctl_b}, 32'h11223344);
      check("R10 pol kept", {pol_a, pol_b}, 2'b10);

      send(8'h57); send(8'h50); send(8'h50); send(8'h0C);
      check("R13 no reply", tx_valid, 0);
      check("R13 fields", {duty_a, duty_b, ctl_a, ctl_b}, 32'h505000FF);
      check("R13 pols", {pol_a, pol_b}, 2'b01);

      dist_front = 16'h1234; dist_back = 16'hABCD;
      send(8'h43); send(8'h43); send(8'h43); send(8'h43);
      q.delete();
      for (int k = 0; k < 3; k++) begin
         q.push_back(8'h43); q.push_back(8'h34); q.push_back(8'h12);
         q.push_back(8'hCD); q.push_back(8'hAB);
      end
      q.push_back(8'h43);
      expect_reply("R11 full drop", q);

      send(8'h77); send(8'h01); send(8'h02); send(8'h03); send(8'h04);
      send(8'h50);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      check("R12 queue cleared", tx_valid, 0);
      check("R12 motors cleared", {duty_a, ctl_a, duty_b, ctl_b, pol_a, pol_b}, 0);

      // random traffic with acknowledges arriving at any time
      for (int c = 0; c < 3000; c++) begin
         int r;
         r = int'($urandom % 10);
         rx_valid = ($urandom % 3) == 0;
         case (r)
            0: rx_byte = 8'h50;
            1: rx_byte = 8'h43;
            2: rx_byte = 8'h44;
            3: rx_byte = 8'h63;
            4: rx_byte = 8'h57;
            5: rx_byte = 8'h77;
            default: rx_byte = 8'($urandom);
         endcase
         tx_ack = ($urandom % 2) == 0;
         if ($urandom % 8 == 0) dist_front = 16'($urandom);
         if ($urandom % 8 == 0) dist_back = 16'($urandom);
         if ($urandom % 8 == 0) enc_left = 16'($urandom);
         if ($urandom % 8 == 0) enc_right = 16'($urandom);
         @(negedge clk);
      end
      rx_valid = 1'b0;
      tx_ack = 1'b1;
      repeat (40) @(negedge clk);
      tx_ack = 1'b0;
      @(negedge clk);
      finish_run();
   end
endmodule